// File: doc/BRIEF.md
# Two-Stage Serial Clock Rate Generator

This block derives the serial clock of a two-wire bus master from a much faster input clock. Two programmable prescalers are chained. The first divides by `A+1`, where A is a 2-bit value. The second divides the first one's wrap pulses by `B+1`, where B is a 6-bit value. The result is a "unit" of `U = (A+1)*(B+1)` input cycles. A fixed counter of 22 units then forms one serial clock period, so the bus clock runs at `Fin / (22*(A+1)*(B+1))`. The fastest rate is `Fin/22`, reached with A = B = 0.

The period is split into 11 low units followed by 11 high units. Three single-cycle strobes are produced for a bit-level sequencer: one at the falling edge, one at the point where data may change inside the low phase, and one at the sample point inside the high phase.

The divider values pass through shadow registers. These follow the inputs only while the bus is inactive, so a period that is in progress always runs at the rate it started with. While the enable is low, the clock rests high and all counters stay at zero.

Top module: `scl_rate_gen`

## Requirements
- R1: A synchronous active-high reset forces `scl_o` high, all three strobes low and both shadow divider values to zero.
- R2: In every cycle that follows a clock edge at which `bus_en` was low, `scl_o` is high and all strobes are low.
- R3: Let `U = (A+1)*(B+1)` input cycles, where A is `div_a` (2 bits, factor 1..4) and B is `div_b` (6 bits, factor 1..64). One serial clock period lasts exactly `22*U` input cycles.
- R4: Number the cycles from the first clock edge at which `bus_en` is high, counting that edge as position 0. Positions advance modulo `22*U`. `scl_o` is low for positions `0 .. 11*U-1` and high for positions `11*U .. 22*U-1`.
- R5: `tick_fall` is high for exactly one cycle at position 0 of every period, including the first period after enable.
- R6: `tick_mid_low` is high for one cycle at position `5*U`. `tick_mid_high` is high for one cycle at position `16*U`.
- R7: The shadow dividers copy `div_a`/`div_b` at every clock edge where `bus_en` is low. Changes while `bus_en` is high have no effect on the running period length. A change presented at the same edge where `bus_en` rises is not taken.
- R8: When `bus_en` is dropped, the block becomes idle at the next edge. A later enable restarts at position 0 with the freshly captured dividers.
- R9: With A = 0 and B = 0 the period is 22 cycles: 11 cycles low and 11 cycles high.
- R10: At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus active; high runs the clock, low idles it and opens the shadow registers |
| div_a | input | 2 | First prescaler value A (factor A+1) |
| div_b | input | 6 | Second prescaler value B (factor B+1) |
| scl_o | output | 1 | Serial clock level |
| tick_fall | output | 1 | One-cycle strobe at the start of the low phase |
| tick_mid_low | output | 1 | One-cycle strobe at the data-change point |
| tick_mid_high | output | 1 | One-cycle strobe at the sample point |

## Verification
Two functions can meet at one edge: shadow capture and the start of counting. They collide when new divider values and the rising enable are presented in the same cycle. The bench provokes this on purpose, with a large jump in the values, and expects the first period to use the values captured one edge earlier. It judges this by comparing every output in every cycle against a position model driven by the old unit length. A second collision is a disable and re-enable with new values. There the restart must begin at position 0 at the new rate, with no stale count carried over.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int unsigned DIVA_W        = 2;
    localparam int unsigned DIVB_W        = 6;
    localparam int unsigned UNITS_PER_PER = 22;
    localparam int unsigned LOW_UNITS     = 11;
    localparam int unsigned MID_LOW_UNIT  = 5;
    localparam int unsigned MID_HIGH_UNIT = 16;
    localparam int unsigned PHASE_W       = $clog2(UNITS_PER_PER);

    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        logic [DIVA_W-1:0] a;
        logic [DIVB_W-1:0] b;
    } div_cfg_t;

    typedef struct packed {
        logic scl;
        logic fall;
        logic mid_low;
        logic mid_high;
    } scl_out_t;

    localparam scl_out_t OUT_IDLE = '{scl: 1'b1, fall: 1'b0, mid_low: 1'b0, mid_high: 1'b0};

    function automatic div_cfg_t pack_cfg(logic [DIVA_W-1:0] a, logic [DIVB_W-1:0] b);
        div_cfg_t c;
        c.a = a;
        c.b = b;
        return c;
    endfunction

    // Output decode of a position given as (running, unit index, first cycle of unit)
    function automatic scl_out_t decode_out(logic live, phase_t ph, logic unit_start);
        scl_out_t o;
        if (!live) begin
            o = OUT_IDLE;
        end else begin
            o.scl      = (ph >= phase_t'(LOW_UNITS));
            o.fall     = unit_start && (ph == phase_t'(0));
            o.mid_low  = unit_start && (ph == phase_t'(MID_LOW_UNIT));
            o.mid_high = unit_start && (ph == phase_t'(MID_HIGH_UNIT));
        end
        return o;
    endfunction

endpackage

// File: rtl/scl_div_shadow.sv
module scl_div_shadow
    import scl_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_en,
    input  div_cfg_t cfg_i,
    output div_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!bus_en) begin
            cfg_q <= cfg_i;
        end
    end

    // R7: values frozen for the whole time the bus is active
    p_hold_active_r7: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> $stable(cfg_q))
        else $error("shadow changed while bus active");

endmodule

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);

    assign wrap = adv && (cnt_q == limit);

    always_comb begin
        if (clr) begin
            cnt_nxt = '0;
        end else if (wrap) begin
            cnt_nxt = '0;
        end else if (adv) begin
            cnt_nxt = cnt_q + W'(1);
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // R3: a prescaler never runs past its programmed limit
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit)
        else $error("prescaler count beyond limit");

endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
    import scl_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_en,
    input  logic     unit_wrap,
    input  logic     unit_start_nxt,
    output logic     run,
    output scl_out_t out_q
);

    localparam phase_t PH_LAST = phase_t'(UNITS_PER_PER - 1);

    logic   live_q;
    phase_t phase_q;
    phase_t phase_nxt;

    assign run = bus_en && live_q;

    always_comb begin
        if (!run) begin
            phase_nxt = '0;
        end else if (unit_wrap) begin
            phase_nxt = (phase_q == PH_LAST) ? '0 : phase_q + phase_t'(1);
        end else begin
            phase_nxt = phase_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= 1'b0;
            phase_q <= '0;
            out_q   <= OUT_IDLE;
        end else begin
            live_q  <= bus_en;
            phase_q <= phase_nxt;
            out_q   <= decode_out(bus_en, phase_nxt, unit_start_nxt);
        end
    end

    // R4: unit index stays within one period
    p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PH_LAST)
        else $error("phase index out of range");

    // R2: idle level one edge after the enable is seen low
    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_en |=> (out_q.scl && !out_q.fall && !out_q.mid_low && !out_q.mid_high))
        else $error("not idle after disable");

    // R5: the fall strobe marks a true high-to-low transition
    p_fall_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q.fall) |-> (!out_q.scl && $fell(out_q.scl)))
        else $error("fall strobe without falling edge");

    // R10: strobes are mutually exclusive
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_q.fall, out_q.mid_low, out_q.mid_high}))
        else $error("more than one strobe");

    // R6: data-change point lies in the low phase, sample point in the high phase
    p_mid_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (out_q.mid_low |-> !out_q.scl) and (out_q.mid_high |-> out_q.scl))
        else $error("mid strobe in wrong phase");

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter int unsigned A_W = DIVA_W,
    parameter int unsigned B_W = DIVB_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_en,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    output logic           scl_o,
    output logic           tick_fall,
    output logic           tick_mid_low,
    output logic           tick_mid_high
);

    div_cfg_t       cfg_sh;
    logic           run;
    logic [A_W-1:0] a_cnt, a_nxt;
    logic [B_W-1:0] b_cnt, b_nxt;
    logic           a_wrap, b_wrap;
    logic           unit_start_nxt;
    scl_out_t       outs;

    scl_div_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .bus_en (bus_en),
        .cfg_i  (pack_cfg(DIVA_W'(div_a), DIVB_W'(div_b))),
        .cfg_q  (cfg_sh)
    );

    scl_div_stage #(.W(A_W)) u_stage_a (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run),
        .adv     (run),
        .limit   (A_W'(cfg_sh.a)),
        .cnt_q   (a_cnt),
        .cnt_nxt (a_nxt),
        .wrap    (a_wrap)
    );

    scl_div_stage #(.W(B_W)) u_stage_b (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run),
        .adv     (a_wrap),
        .limit   (B_W'(cfg_sh.b)),
        .cnt_q   (b_cnt),
        .cnt_nxt (b_nxt),
        .wrap    (b_wrap)
    );

    assign unit_start_nxt = (a_nxt == '0) && (b_nxt == '0);

    scl_div_phase u_phase (
        .clk            (clk),
        .rst            (rst),
        .bus_en         (bus_en),
        .unit_wrap      (a_wrap && b_wrap),
        .unit_start_nxt (unit_start_nxt),
        .run            (run),
        .out_q          (outs)
    );

    assign scl_o         = outs.scl;
    assign tick_fall     = outs.fall;
    assign tick_mid_low  = outs.mid_low;
    assign tick_mid_high = outs.mid_high;

    // R3: the second prescaler only moves on a wrap of the first
    p_cascade_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !a_wrap) |=> $stable(b_cnt))
        else $error("second stage moved without first-stage wrap");

endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       scl_o, tick_fall, tick_mid_low, tick_mid_high;

    always #2.5 clk = ~clk;

    scl_rate_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_en        (bus_en),
        .div_a         (div_a),
        .div_b         (div_b),
        .scl_o         (scl_o),
        .tick_fall     (tick_fall),
        .tick_mid_low  (tick_mid_low),
        .tick_mid_high (tick_mid_high)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    started  = 0;
    bit    finished = 0;

    // reference position model built from the requirements
    bit m_live = 0;
    int m_pos  = 0;
    int m_a    = 0;
    int m_b    = 0;

    function automatic int unit_len(int a, int b);
        return (a + 1) * (b + 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            started <= 1;
            m_live  <= 0;
            m_pos   <= 0;
            m_a     <= 0;
            m_b     <= 0;
        end else if (!bus_en) begin
            m_a     <= int'(div_a);
            m_b     <= int'(div_b);
            m_live  <= 0;
            m_pos   <= 0;
        end else if (!m_live) begin
            m_live  <= 1;
            m_pos   <= 0;
        end else begin
            m_pos   <= (m_pos + 1) % (22 * unit_len(m_a, m_b));
        end
    end

    task automatic chk(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual=%b expected=%b pos=%0d U=%0d t=%0t",
                     req, cur_req, what, act, exp, m_pos, unit_len(m_a, m_b), $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            int u;
            u = unit_len(m_a, m_b);
            if (!m_live) begin
                chk((rst ? "R1" : "R2"), scl_o, 1'b1, "idle scl");
                chk((rst ? "R1" : "R2"), tick_fall | tick_mid_low | tick_mid_high, 1'b0, "idle strobes");
            end else begin
                chk("R4", scl_o, (m_pos >= 11 * u), "scl level");
                chk("R5", tick_fall, (m_pos == 0), "fall strobe");
                chk("R6", tick_mid_low, (m_pos == 5 * u), "mid-low strobe");
                chk("R6", tick_mid_high, (m_pos == 16 * u), "mid-high strobe");
                chk("R10", ((32'(tick_fall) + 32'(tick_mid_low) + 32'(tick_mid_high)) <= 1), 1'b1, "strobe exclusivity");
            end
        end
    end

    task automatic set_cfg(int a, int b);
        div_a = 2'(a);
        div_b = 6'(b);
    endtask

    task automatic run_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // measure one full period via fall strobes (R3/R9)
    task automatic measure_period(int exp_len, string req);
        int cnt;
        cnt = 0;
        while (tick_fall !== 1'b1 && cnt < 20000) begin @(negedge clk); cnt++; end
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (tick_fall !== 1'b1 && cnt < 20000);
        n_checks++;
        if (cnt != exp_len) begin
            n_fail++;
            $display("FAIL %s period length: actual=%0d expected=%0d", req, cnt, exp_len);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h2b7e_1516));
        cur_req = "R1";
        @(negedge clk);
        run_cycles(4);
        rst = 1'b0;
        cur_req = "R2";
        set_cfg(2, 7);
        run_cycles(10);

        // R9: fastest rate, 22-cycle period
        cur_req = "R9";
        set_cfg(0, 0);
        run_cycles(2);
        bus_en = 1'b1;
        measure_period(22, "R9");
        run_cycles(50);
        bus_en = 1'b0;
        run_cycles(3);

        // R3: slowest setting, unit of 256 cycles
        cur_req = "R3";
        set_cfg(3, 63);
        run_cycles(2);
        bus_en = 1'b1;
        measure_period(22 * 256, "R3");
        bus_en = 1'b0;
        run_cycles(3);

        // random configurations
        for (int i = 0; i < 6; i++) begin
            int a, b;
            cur_req = "R4";
            a = int'($urandom_range(0, 3));
            b = int'($urandom_range(0, 15));
            set_cfg(a, b);
            run_cycles(1 + int'($urandom_range(0, 3)));
            bus_en = 1'b1;
            run_cycles(22 * unit_len(a, b) + 7 + int'($urandom_range(0, 30)));
            bus_en = 1'b0;
            run_cycles(1 + int'($urandom_range(0, 2)));
        end

        // R7: changes while active are ignored
        cur_req = "R7";
        set_cfg(1, 2);
        run_cycles(2);
        bus_en = 1'b1;
        run_cycles(17);
        set_cfg(3, 9);
        measure_period(22 * 6, "R7");
        run_cycles(40);

        // R8: drop and restart with new values at position 0
        cur_req = "R8";
        bus_en = 1'b0;
        run_cycles(2);
        bus_en = 1'b1;
        run_cycles(1);
        chk("R8", tick_fall, 1'b1, "restart fall strobe");
        measure_period(22 * 40, "R8");
        bus_en = 1'b0;
        run_cycles(2);

        // R7: new values at the same edge the enable rises are not taken
        cur_req = "R7";
        set_cfg(0, 1);
        run_cycles(3);
        set_cfg(3, 20);
        bus_en = 1'b1;
        measure_period(22 * 2, "R7");
        run_cycles(60);

        // R1: reset while running
        cur_req = "R1";
        rst = 1'b1;
        run_cycles(3);
        rst = 1'b0;
        bus_en = 1'b0;
        run_cycles(5);
        finish_run();
    end

endmodule